// File: doc/BRIEF.md
# Four-Mode Timer with Variable-Width PWM

This block is a 16-bit count unit that can be split into two 8-bit halves or used whole. A two-bit mode field picks one of four arrangements. Mode 0 gives two independent 8-bit interval timers. Mode 1 gives an 8-bit interval timer in the low half and a free-running 8-bit PWM in the high half. Mode 2 gives a single 16-bit interval timer. Mode 3 gives a single PWM whose period width can be set anywhere from 9 to 16 bits. Every count event raises a one-cycle strobe on the low or high event output, and both strobes are meant to be merged into one interrupt request.

The block runs on a fast clock at twice the instruction rate. Normally a count happens once per instruction cycle, which is every second fast-clock cycle. In modes 2 and 3 a resolution bit can select half-cycle resolution, and the count then advances on every fast-clock cycle. The PWM duty value passes through a shadow register. The shadow is reloaded only when the period wraps, so a period is never cut short or stretched by a write.

Dropping `run` stops the block and clears it. All outputs are registered.

Top module: `pwm_timer16`

## Requirements
- R1: While `run` is low, and after reset, `flag_lo`, `flag_hi` and `pwm_out` are low one cycle later and the counters restart from zero.
- R2: In mode 0 (`mode_sel`=0), `flag_lo` pulses once every 2·(`match_lo`+1) clocks and `flag_hi` pulses once every 2·(`match_hi`+1) clocks.
- R3: In mode 1 (`mode_sel`=1), the low half behaves as in R2. The high half is an 8-bit PWM with a period of 512 clocks, and `flag_hi` pulses on the first clock of each period. `pwm_out` is high for 2·D clocks of each period, where D is `duty[8:0]` and D is below 256.
- R4: In mode 2 (`mode_sel`=2), `flag_hi` pulses once every T·(M+1) clocks, where M = {`match_hi`,`match_lo`}, and `flag_lo` stays low.
- R5: In mode 3 (`mode_sel`=3), the width is N = 9 + `width_sel`. The count wraps after 2^N−1, so the period is T·2^N clocks, and `flag_hi` marks each period start. `pwm_out` is high for the first T·D clocks of a period, where D < 2^N, and `flag_lo` stays low.
- R6: T is 1 when `fine_res` is 1 and the mode is 2 or 3; otherwise T is 2. `fine_res` has no effect in modes 0 and 1.
- R7: A change of `duty` during a period does not affect that period; it takes effect from the next period.
- R8: A duty of 0 keeps `pwm_out` low for the whole period, and a duty of 2^N or more keeps it high for the whole period, where N is 8 in mode 1.
- R9: In modes 0 and 1, `flag_lo` never pulses on two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the instruction rate |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Count enable; low stops and clears the unit |
| mode_sel | input | 2 | 0 dual timer, 1 timer+PWM, 2 wide timer, 3 variable PWM |
| fine_res | input | 1 | Half-cycle resolution in modes 2 and 3 |
| match_lo | input | 8 | Low-half terminal count (low byte in mode 2) |
| match_hi | input | 8 | High-half terminal count (high byte in mode 2) |
| width_sel | input | 3 | PWM width in mode 3, N = 9 + value |
| duty | input | 17 | PWM duty value, loaded into the shadow at wrap |
| pwm_out | output | 1 | PWM output |
| flag_lo | output | 1 | Low-half event strobe |
| flag_hi | output | 1 | High-half or full-width event strobe |

## Verification
The hardest case to reach from the ports is a duty write landing in the middle of a running period. The bench must show that the write is held off until the wrap, while the count runs at the correct resolution. To do this, the bench locks onto a `flag_hi` pulse, counts a fixed number of clocks into the high phase, and rewrites `duty` there. It then compares the high time of that period and of the next one against the old and new values. Constrained random match, width and duty values, each measured between consecutive event strobes, cover the period arithmetic of every mode. Directed duty values of 0 and 2^N pin down the two saturated ends.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  typedef enum logic [1:0] {
    MODE_DUAL    = 2'd0,
    MODE_TMR_PWM = 2'd1,
    MODE_WIDE    = 2'd2,
    MODE_VARPWM  = 2'd3
  } tmr_mode_e;
endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic fast,
  output logic tick
);
  logic phase_q;

  always_ff @(posedge clk) begin
    if (rst || !run) phase_q <= 1'b0;
    else             phase_q <= ~phase_q;
  end

  // one count per instruction cycle, or every fast clock when fast is set
  assign tick = run & (fast | phase_q);
endmodule

// File: rtl/pwm_count_core.sv
module pwm_count_core
  import pwm_timer_pkg::*;
#(
  parameter int HALF_W = 8,
  parameter int WSEL_W = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  run,
  input  logic                  tick,
  input  tmr_mode_e             mode,
  input  logic [HALF_W-1:0]     match_lo,
  input  logic [HALF_W-1:0]     match_hi,
  input  logic [WSEL_W-1:0]     wsel,
  output logic [2*HALF_W-1:0]   cnt_nxt,
  output logic                  wrap_lo,
  output logic                  wrap_hi
);
  localparam int W  = 2 * HALF_W;
  localparam int NW = $clog2(W + 1);
  localparam logic [HALF_W-1:0] ONE_H = 1;
  localparam logic [W-1:0]      ONE_W = 1;
  localparam logic [W:0]        ONE_X = 1;

  logic [W-1:0]      cnt_q;
  logic [HALF_W-1:0] lo, hi, nlo, nhi;
  logic [NW-1:0]     width_n;
  logic [W:0]        lim;
  logic [W-1:0]      var_top, top;

  assign lo = cnt_q[HALF_W-1:0];
  assign hi = cnt_q[W-1:HALF_W];

  // terminal count of the variable-width PWM: 2^N - 1
  assign width_n = NW'(HALF_W + 1) + NW'(wsel);
  assign lim     = (ONE_X << width_n) - ONE_X;
  assign var_top = lim[W-1:0];
  assign top     = (mode == MODE_WIDE) ? {match_hi, match_lo} : var_top;

  always_comb begin
    cnt_nxt = cnt_q;
    wrap_lo = 1'b0;
    wrap_hi = 1'b0;
    nlo     = lo;
    nhi     = hi;
    if (!run) begin
      cnt_nxt = '0;
    end else if (tick) begin
      case (mode)
        MODE_DUAL, MODE_TMR_PWM: begin
          if (lo >= match_lo) begin
            nlo     = '0;
            wrap_lo = 1'b1;
          end else begin
            nlo = lo + ONE_H;
          end
          if (mode == MODE_DUAL) begin
            if (hi >= match_hi) begin
              nhi     = '0;
              wrap_hi = 1'b1;
            end else begin
              nhi = hi + ONE_H;
            end
          end else begin
            nhi     = hi + ONE_H;
            wrap_hi = (hi == {HALF_W{1'b1}});
          end
          cnt_nxt = {nhi, nlo};
        end
        default: begin
          if (cnt_q >= top) begin
            cnt_nxt = '0;
            wrap_hi = 1'b1;
          end else begin
            cnt_nxt = cnt_q + ONE_W;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/pwm_duty_cmp.sv
module pwm_duty_cmp
  import pwm_timer_pkg::*;
#(
  parameter int HALF_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 run,
  input  tmr_mode_e            mode,
  input  logic                 load,
  input  logic [2*HALF_W:0]    duty,
  input  logic [2*HALF_W-1:0]  cnt_nxt,
  output logic                 pwm_nxt
);
  localparam int W = 2 * HALF_W;

  logic [W:0] shadow_q, shadow_nxt, cmp_val;
  logic       pwm_mode;

  // shadow follows the input while idle, otherwise only at wrap
  assign shadow_nxt = (!run || load) ? duty : shadow_q;

  always_ff @(posedge clk) begin
    if (rst) shadow_q <= '0;
    else     shadow_q <= shadow_nxt;
  end

  assign pwm_mode = (mode == MODE_VARPWM) || (mode == MODE_TMR_PWM);
  assign cmp_val  = (mode == MODE_VARPWM) ? {1'b0, cnt_nxt}
                                          : {{(HALF_W+1){1'b0}}, cnt_nxt[W-1:HALF_W]};
  assign pwm_nxt  = run && pwm_mode && (cmp_val < shadow_nxt);
endmodule

// File: rtl/pwm_timer16.sv
module pwm_timer16
  import pwm_timer_pkg::*;
#(
  parameter int HALF_W = 8,
  parameter int WSEL_W = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 run,
  input  logic [1:0]           mode_sel,
  input  logic                 fine_res,
  input  logic [HALF_W-1:0]    match_lo,
  input  logic [HALF_W-1:0]    match_hi,
  input  logic [WSEL_W-1:0]    width_sel,
  input  logic [2*HALF_W:0]    duty,
  output logic                 pwm_out,
  output logic                 flag_lo,
  output logic                 flag_hi
);
  localparam int W = 2 * HALF_W;

  tmr_mode_e  mode;
  logic       fast, tick, wrap_lo, wrap_hi, pwm_nxt;
  logic [W-1:0] cnt_nxt;

  assign mode = tmr_mode_e'(mode_sel);
  // half-cycle resolution only in the full-width modes
  assign fast = fine_res & mode_sel[1];

  pwm_tick_gen u_tick (
    .clk (clk), .rst (rst), .run (run), .fast (fast), .tick (tick)
  );

  pwm_count_core #(.HALF_W(HALF_W), .WSEL_W(WSEL_W)) u_core (
    .clk (clk), .rst (rst), .run (run), .tick (tick), .mode (mode),
    .match_lo (match_lo), .match_hi (match_hi), .wsel (width_sel),
    .cnt_nxt (cnt_nxt), .wrap_lo (wrap_lo), .wrap_hi (wrap_hi)
  );

  pwm_duty_cmp #(.HALF_W(HALF_W)) u_cmp (
    .clk (clk), .rst (rst), .run (run), .mode (mode), .load (wrap_hi),
    .duty (duty), .cnt_nxt (cnt_nxt), .pwm_nxt (pwm_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_out <= 1'b0;
      flag_lo <= 1'b0;
      flag_hi <= 1'b0;
    end else begin
      pwm_out <= pwm_nxt;
      flag_lo <= wrap_lo;
      flag_hi <= wrap_hi;
    end
  end
endmodule

// File: rtl/pwm_timer16_chk.sv
module pwm_timer16_chk #(
  parameter int HALF_W = 8,
  parameter int WSEL_W = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 run,
  input logic [1:0]           mode_sel,
  input logic [2*HALF_W:0]    duty,
  input logic                 pwm_out,
  input logic                 flag_lo,
  input logic                 flag_hi
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!flag_lo && !flag_hi && !pwm_out));

  p_lo_silent_r4: assert property (@(posedge clk) disable iff (rst)
    $past(run && mode_sel[1]) |-> !flag_lo);

  // at a mode-3 period start the output shows whether the new duty is zero
  p_wrap_duty_r8: assert property (@(posedge clk) disable iff (rst)
    (flag_hi && $past(run && mode_sel == 2'd3)) |-> (pwm_out == ($past(duty) != '0)));

  p_lo_gap_r9: assert property (@(posedge clk) disable iff (rst)
    flag_lo |=> !flag_lo);
endmodule

bind pwm_timer16 pwm_timer16_chk #(.HALF_W(HALF_W), .WSEL_W(WSEL_W)) u_chk (
  .clk (clk), .rst (rst), .run (run), .mode_sel (mode_sel), .duty (duty),
  .pwm_out (pwm_out), .flag_lo (flag_lo), .flag_hi (flag_hi)
);

// File: tb/tb_pwm_timer16.sv
module tb_pwm_timer16;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst, run, fine_res;
  logic [1:0]  mode_sel;
  logic [7:0]  match_lo, match_hi;
  logic [2:0]  width_sel;
  logic [16:0] duty;
  logic        pwm_out, flag_lo, flag_hi;

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_timer16 dut (
    .clk (clk), .rst (rst), .run (run), .mode_sel (mode_sel), .fine_res (fine_res),
    .match_lo (match_lo), .match_hi (match_hi), .width_sel (width_sel),
    .duty (duty), .pwm_out (pwm_out), .flag_lo (flag_lo), .flag_hi (flag_hi)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int res_step(input int mode, input bit fine);
    return (fine && mode >= 2) ? 1 : 2;
  endfunction

  task automatic configure(input int mode, input bit fine, input int mlo,
                           input int mhi, input int ws, input int d);
    @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    mode_sel  = 2'(mode);
    fine_res  = fine;
    match_lo  = 8'(mlo);
    match_hi  = 8'(mhi);
    width_sel = 3'(ws);
    duty      = 17'(d);
    @(negedge clk);
    run = 1'b1;
  endtask

  // window from one event strobe to the next; swap_at < 0 disables duty swap
  task automatic measure(input bit hi_sel, input int swap_at, input int new_d,
                         output int len, output int highs, output int lo_hits);
    len = 0; highs = 0; lo_hits = 0;
    @(negedge clk);
    while (!(hi_sel ? flag_hi : flag_lo)) @(negedge clk);
    do begin
      highs   += int'(pwm_out);
      lo_hits += int'(flag_lo);
      if (len == swap_at) duty = 17'(new_d);
      len++;
      @(negedge clk);
    end while (!(hi_sel ? flag_hi : flag_lo));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int len, highs, hits, m, d, ws, n;
    void'($urandom(32'd20240611));
    rst = 1'b1; run = 1'b0; mode_sel = 2'd0; fine_res = 1'b0;
    match_lo = '0; match_hi = '0; width_sel = '0; duty = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 pwm_out after reset", int'(pwm_out), 0);
    chk("R1 flag_lo after reset", int'(flag_lo), 0);
    chk("R1 flag_hi after reset", int'(flag_hi), 0);
    rst = 1'b0;

    // R2 dual 8-bit timers
    for (int i = 0; i < 3; i++) begin
      m = $urandom_range(0, 40);
      d = $urandom_range(0, 40);
      configure(0, 1'b0, m, d, 0, 0);
      measure(1'b0, -1, 0, len, highs, hits);
      chk("R2 low timer interval", len, 2 * (m + 1));
      measure(1'b1, -1, 0, len, highs, hits);
      chk("R2 high timer interval", len, 2 * (d + 1));
    end

    // R6 fine resolution ignored in mode 0
    m = $urandom_range(1, 30);
    configure(0, 1'b1, m, 5, 0, 0);
    measure(1'b0, -1, 0, len, highs, hits);
    chk("R6 fine ignored in mode 0", len, res_step(0, 1'b1) * (m + 1));

    // R3 timer plus 8-bit PWM
    for (int i = 0; i < 2; i++) begin
      m = $urandom_range(0, 40);
      d = $urandom_range(1, 255);
      configure(1, 1'b0, m, 0, 0, d);
      measure(1'b0, -1, 0, len, highs, hits);
      chk("R3 low timer interval", len, 2 * (m + 1));
      measure(1'b1, -1, 0, len, highs, hits);
      chk("R3 pwm period", len, 512);
      chk("R3 pwm high time", highs, 2 * d);
    end
    // R8 saturated duty in mode 1
    configure(1, 1'b1, 3, 0, 0, 300);
    measure(1'b1, -1, 0, len, highs, hits);
    chk("R8 mode 1 duty>=256 high", highs, len);
    chk("R6 fine ignored in mode 1", len, 512);

    // R4 wide timer, R6 fine resolution
    for (int i = 0; i < 2; i++) begin
      m = $urandom_range(0, 600);
      configure(2, 1'b0, m & 255, m >> 8, 0, 0);
      measure(1'b1, -1, 0, len, highs, hits);
      chk("R4 wide interval", len, 2 * (m + 1));
      chk("R4 flag_lo silent", hits, 0);
      configure(2, 1'b1, m & 255, m >> 8, 0, 0);
      measure(1'b1, -1, 0, len, highs, hits);
      chk("R6 wide fine interval", len, m + 1);
    end

    // R5 variable-width PWM
    for (int i = 0; i < 3; i++) begin
      ws = $urandom_range(0, 1);
      n  = 1 << (9 + ws);
      d  = $urandom_range(1, n - 1);
      configure(3, 1'b0, 0, 0, ws, d);
      measure(1'b1, -1, 0, len, highs, hits);
      chk("R5 pwm period", len, 2 * n);
      chk("R5 pwm high time", highs, 2 * d);
      chk("R5 flag_lo silent", hits, 0);
    end
    // R6 fine resolution in mode 3, width 12
    d = $urandom_range(1, 4095);
    configure(3, 1'b1, 0, 0, 3, d);
    measure(1'b1, -1, 0, len, highs, hits);
    chk("R6 fine pwm period", len, 4096);
    chk("R6 fine pwm high time", highs, d);

    // R8 saturated ends, width 9
    configure(3, 1'b0, 0, 0, 0, 0);
    measure(1'b1, -1, 0, len, highs, hits);
    chk("R8 duty 0 low", highs, 0);
    configure(3, 1'b0, 0, 0, 0, 512);
    measure(1'b1, -1, 0, len, highs, hits);
    chk("R8 duty 2^N high", highs, 1024);

    // R7 mid-period duty change
    configure(3, 1'b0, 0, 0, 0, 100);
    measure(1'b1, 50, 300, len, highs, hits);
    chk("R7 old duty kept", highs, 200);
    measure(1'b1, -1, 0, len, highs, hits);
    chk("R7 new duty next period", highs, 600);

    // R1 stop clears outputs
    @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R1 idle pwm_out", int'(pwm_out), 0);
    chk("R1 idle flags", int'(flag_lo | flag_hi), 0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule